// File: doc/BRIEF.md
# Repeated-Subtraction Unsigned Divider

This block divides one unsigned operand by another by subtracting the divisor from a running remainder, one subtraction per clock, and counting the subtractions. The count is the quotient. What is left once the remainder is smaller than the divisor is the remainder. A three-state Moore controller sequences a datapath that holds the remainder, the divisor and the quotient, and that has a single subtractor. The subtractor's borrow output is the only magnitude test. No separate comparator is used.

While idle, the block keeps reloading its operands from the inputs and keeps the quotient at zero. Raising `start` launches the division. When the result is ready, `done` rises and the result is frozen. It stays frozen until the requester drops `start`. A zero divisor does not start the loop. It sends the block straight to the finished state with `div_zero` set and the operands left as they were loaded. The operand width is a parameter. The subtractor can be built as a plain arithmetic expression or as an explicit borrow chain.

Top module: `subdiv_top`

## Requirements
- R1: After reset, with `start` low, `done` and `div_zero` are 0 and `quotient` reads 0.
- R2: While idle, `remainder` shows the value on `dividend_in` from the previous clock edge and `quotient` stays 0.
- R3: For a nonzero divisor, when `done` is high, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor. The operands are the input values captured on the edge that accepted `start`.
- R4: With a nonzero divisor, `done` first reads 1 after exactly quotient+2 rising edges, counting the edge that accepted `start` as the first.
- R5: While `done` is high, `quotient` and `remainder` hold their values, whatever happens on `dividend_in` and `divisor_in`.
- R6: `done` stays high as long as `start` stays high. It reads 0 one edge after `start` is sampled low. The block is idle again from that edge on.
- R7: A divisor of 0 makes `done` and `div_zero` read 1 one edge after `start` is accepted. In that case `quotient` is 0 and `remainder` equals the captured dividend.
- R8: A dividend smaller than the divisor finishes after 2 edges, with quotient 0 and remainder equal to the dividend.
- R9: `div_zero` is 0 whenever the captured divisor was nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request; must be held until `done` is seen, then dropped |
| dividend_in | input | W | Unsigned dividend |
| divisor_in | input | W | Unsigned divisor |
| done | output | 1 | Result valid and frozen |
| div_zero | output | 1 | Finished because the divisor was 0 (valid with `done`) |
| quotient | output | W | Quotient |
| remainder | output | W | Remainder; follows the dividend while idle |

## Verification
The bench targets the ends of the loop. A divisor of one with the largest dividend runs the longest loop and would expose a quotient counter that wraps or an off-by-one exit. Equal operands and an exact multiple expose a test that treats R = B as "below", which would give the quotient one too low and the remainder equal to the divisor. A dividend below the divisor and a zero dividend check that the block leaves on the first comparison. A divisor of zero would hang a design without the guard, or set the wrong flag. Changing the operands while `done` is held, and then dropping `start`, shows whether a design keeps loading in its finished state or forgets to return to idle. The edge count to `done` catches an extra or missing state cycle.

// File: rtl/subdiv_pkg.sv
package subdiv_pkg;

   // One-hot controller encoding
   typedef enum logic [2:0] {
      ST_LOAD = 3'b001,
      ST_STEP = 3'b010,
      ST_HOLD = 3'b100
   } subdiv_state_e;

   // Moore control word issued by the controller
   typedef struct packed {
      logic clr_q;   // clear quotient
      logic ld_b;    // capture divisor
      logic ld_r;    // write remainder
      logic r_sel;   // 0: dividend input, 1: difference
      logic inc_q;   // count a subtraction (gated by ge)
   } subdiv_ctl_t;

endpackage

// File: rtl/subdiv_sub.sv
module subdiv_sub #(
   parameter int W      = 8,
   parameter int IMPL   = 0    // 0: arithmetic expression, 1: explicit borrow chain
) (
   input  logic [W-1:0] minuend,
   input  logic [W-1:0] subtrahend,
   output logic [W-1:0] diff,
   output logic         borrow
);

   if (W < 2) begin : g_bad_width
      $error("subdiv_sub: W must be at least 2");
   end
   if (IMPL != 0 && IMPL != 1) begin : g_bad_impl
      $error("subdiv_sub: IMPL must be 0 or 1");
   end

   if (IMPL == 0) begin : g_arith
      logic [W:0] wide;
      always_comb begin
         wide   = {1'b0, minuend} - {1'b0, subtrahend};
         diff   = wide[W-1:0];
         borrow = wide[W];
      end
   end else begin : g_chain
      logic [W:0] bw;
      assign bw[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign diff[i]  = minuend[i] ^ subtrahend[i] ^ bw[i];
         assign bw[i+1]  = (~minuend[i] & subtrahend[i]) |
                           (~(minuend[i] ^ subtrahend[i]) & bw[i]);
      end
      assign borrow = bw[W];
   end

endmodule

// File: rtl/subdiv_ctrl.sv
module subdiv_ctrl
   import subdiv_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        divisor_zero,  // combinational test of the divisor input
   input  logic        ge,            // remainder >= divisor, from subtractor borrow
   output subdiv_ctl_t ctl,
   output logic        done,
   output logic        err
);

   subdiv_state_e state_q, state_d;
   logic          err_q, err_d;

   always_comb begin
      state_d = state_q;
      err_d   = err_q;
      unique case (state_q)
         ST_LOAD: begin
            err_d = 1'b0;
            if (start) begin
               err_d   = divisor_zero;
               state_d = divisor_zero ? ST_HOLD : ST_STEP;
            end
         end
         ST_STEP: begin
            if (!ge) state_d = ST_HOLD;
         end
         ST_HOLD: begin
            if (!start) state_d = ST_LOAD;
         end
         default: state_d = ST_LOAD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_LOAD;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= err_d;
      end
   end

   // Moore decode: outputs depend on state only
   always_comb begin
      ctl = '0;
      unique case (state_q)
         ST_LOAD: begin
            ctl.clr_q = 1'b1;
            ctl.ld_b  = 1'b1;
            ctl.ld_r  = 1'b1;
            ctl.r_sel = 1'b0;
         end
         ST_STEP: begin
            ctl.ld_r  = 1'b1;
            ctl.r_sel = 1'b1;
            ctl.inc_q = 1'b1;
         end
         default: ctl = '0;
      endcase
   end

   assign done = (state_q == ST_HOLD);
   assign err  = err_q & done;

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_q) == 1);                                             // R6
   AST_ZERO_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOAD) && start && divisor_zero |=> done && err);        // R7
   AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !done);                                             // R6
   AST_DONE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      done && start |=> done);                                               // R6
   AST_NO_ERR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOAD) && start && !divisor_zero |=> !err);              // R9

endmodule

// File: rtl/subdiv_path.sv
module subdiv_path
   import subdiv_pkg::*;
#(
   parameter int W        = 8,
   parameter int SUB_IMPL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  subdiv_ctl_t   ctl,
   input  logic [W-1:0]  dividend_in,
   input  logic [W-1:0]  divisor_in,
   output logic          ge,
   output logic [W-1:0]  q_out,
   output logic [W-1:0]  r_out,
   output logic [W-1:0]  b_out
);

   logic [W-1:0] r_q, b_q, q_q;
   logic [W-1:0] diff;
   logic         borrow;
   logic [W-1:0] r_next;

   subdiv_sub #(.W(W), .IMPL(SUB_IMPL)) u_sub (
      .minuend    (r_q),
      .subtrahend (b_q),
      .diff       (diff),
      .borrow     (borrow)
   );

   // the same subtraction that produces the difference decides R >= B
   assign ge     = ~borrow;
   assign r_next = ctl.r_sel ? diff : dividend_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q <= '0;
         b_q <= '0;
         q_q <= '0;
      end else begin
         if (ctl.ld_r && (!ctl.r_sel || ge)) r_q <= r_next;
         if (ctl.ld_b)                       b_q <= divisor_in;
         if (ctl.clr_q)                      q_q <= '0;
         else if (ctl.inc_q && ge)           q_q <= q_q + 1'b1;
      end
   end

   assign q_out = q_q;
   assign r_out = r_q;
   assign b_out = b_q;

   AST_Q_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.inc_q && ge && !ctl.clr_q |=> q_q == $past(q_q) + 1'b1);           // R3
   AST_R_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.r_sel && ge |=> r_q == $past(r_q) - $past(b_q));                   // R3
   AST_IDLE_Q_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.clr_q |=> q_q == '0);                                              // R2

endmodule

// File: rtl/subdiv_top.sv
module subdiv_top
   import subdiv_pkg::*;
#(
   parameter int W        = 8,
   parameter int SUB_IMPL = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [W-1:0]  dividend_in,
   input  logic [W-1:0]  divisor_in,
   output logic          done,
   output logic          div_zero,
   output logic [W-1:0]  quotient,
   output logic [W-1:0]  remainder
);

   if (W < 2 || W > 32) begin : g_bad_width
      $error("subdiv_top: W must lie in 2..32");
   end

   subdiv_ctl_t  ctl;
   logic         ge;
   logic         zero_div;
   logic [W-1:0] b_held;

   assign zero_div = (divisor_in == '0);

   subdiv_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .divisor_zero (zero_div),
      .ge           (ge),
      .ctl          (ctl),
      .done         (done),
      .err          (div_zero)
   );

   subdiv_path #(.W(W), .SUB_IMPL(SUB_IMPL)) u_path (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl         (ctl),
      .dividend_in (dividend_in),
      .divisor_in  (divisor_in),
      .ge          (ge),
      .q_out       (quotient),
      .r_out       (remainder),
      .b_out       (b_held)
   );

   AST_DONE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      done && $past(done) |-> $stable(quotient) && $stable(remainder));      // R5
   AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      done && !div_zero |-> remainder < b_held);                             // R3

endmodule

// File: tb/test_subdiv_top.sv
`timescale 1ns/1ps
module test_subdiv_top;
   localparam int W = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  dividend_in = '0;
   logic [W-1:0]  divisor_in = '0;
   logic          done, div_zero;
   logic [W-1:0]  quotient, remainder;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   subdiv_top #(.W(W)) i_subdiv_top (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dividend_in(dividend_in), .divisor_in(divisor_in),
      .done(done), .div_zero(div_zero),
      .quotient(quotient), .remainder(remainder)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // Launch a division and return the edge count until done is seen
   task automatic launch(input int a, input int b, output int edges);
      @(negedge clk);
      dividend_in = W'(a);
      divisor_in  = W'(b);
      start       = 1'b1;
      edges = 0;
      for (int k = 0; k < 600; k++) begin
         @(posedge clk);
         edges++;
         @(negedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R4 timeout: actual done=0 expected done=1");
      end
   endtask

   task automatic release_start();
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check("R6", "done after release", int'(done), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", "done after reset", int'(done), 0);
      check("R1", "div_zero after reset", int'(div_zero), 0);
      check("R1", "quotient after reset", int'(quotient), 0);
      dividend_in = 8'd91;
      @(negedge clk);
      check("R2", "idle remainder tracks dividend", int'(remainder), 91);
      check("R2", "idle quotient", int'(quotient), 0);
   endtask

   task automatic t_div(input int a, input int b, input string tag);
      int e;
      launch(a, b, e);
      check(tag, "quotient", int'(quotient), a / b);
      check(tag, "remainder", int'(remainder), a % b);
      check("R4", "edges to done", e, a / b + 2);
      check("R9", "div_zero for nonzero divisor", int'(div_zero), 0);
      release_start();
   endtask

   task automatic t_hold();
      int e;
      launch(100, 7, e);
      dividend_in = 8'd3;
      divisor_in  = 8'd1;
      repeat (3) @(negedge clk);
      check("R5", "done held", int'(done), 1);
      check("R5", "quotient frozen", int'(quotient), 14);
      check("R5", "remainder frozen", int'(remainder), 2);
      release_start();
      @(negedge clk);
      check("R6", "idle again: remainder reloads", int'(remainder), 3);
      check("R6", "idle again: quotient cleared", int'(quotient), 0);
   endtask

   task automatic t_zero();
      int e;
      launch(77, 0, e);
      check("R7", "edges to done", e, 1);
      check("R7", "div_zero", int'(div_zero), 1);
      check("R7", "quotient", int'(quotient), 0);
      check("R7", "remainder", int'(remainder), 77);
      release_start();
      check("R7", "div_zero cleared", int'(div_zero), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_div(100, 7, "R3");
      t_div(48, 6, "R3");
      t_div(255, 255, "R3");
      t_div(255, 1, "R3");
      t_div(5, 9, "R8");
      t_div(0, 3, "R8");
      t_hold();
      t_zero();
      t_div(200, 13, "R3");
      summary();
   end

   initial begin
      #(20ns * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end

endmodule